// File: doc/BRIEF.md
# Temperature Measurement Sequencer

This block decides when a temperature sensor front end converts and when its result is taken in. A single control word written over a simple write strobe turns the block on, requests or aborts measurements, and picks one of three measurement modes and one of four resolutions. Static configuration inputs give the reference clock divider, the power-up delay and the repeat period of periodic mode. The system clock is divided down to a conversion clock, brought out as a one-cycle tick for the front end. Every delay and length the block uses is counted in these ticks.

When it is turned on, the block waits out the power-up delay and then serves start requests. Each conversion holds the front end busy for a window whose length follows from the resolution. It then asks for the sample and waits for the front end's done strobe, which carries a signed 16-bit reading with six fraction bits. The reading is stored and a data-ready flag is raised. Single mode stops after one conversion. Continuous mode restarts at once. Periodic mode starts a conversion on a fixed grid of conversion ticks.

Top module: `tmeas_seq`

## Requirements
- R1: The control word carries enable in bit 31, a start strobe in bit 30, a stop strobe in bit 29, the mode in bits 25:24 (0 single, 1 continuous, 2 periodic, 3 behaves as single) and the resolution in bits 19:18. Start and stop act only in the cycle the word is written.
- R2: While enabled, `conv_tick` pulses once every cycle when the divider is off, and once every `cdiv_val`+1 cycles when it is on. While disabled it never pulses.
- R3: After enable is set, no conversion begins until at least `pud_ticks` conversion ticks have passed. A start written together with enable is held until then.
- R4: `sns_conv` stays high for exactly CONV_BASE + CONV_UNIT·2^res conversion ticks in each conversion.
- R5: After the window, `sns_req` stays high until `sns_done`. On that cycle `sns_data` is stored in `result` and `drdy` is set.
- R6: `sns_done` has no effect while `sns_req` is low: `result` and `drdy` keep their values.
- R7: In single mode one start gives exactly one conversion, after which the block waits for the next start. A start written with enable clear is ignored.
- R8: In continuous mode the next window opens in the cycle after each capture. With an immediate done, consecutive window starts are the window length + 1 ticks apart.
- R9: In periodic mode window starts are exactly `period_ticks` ticks apart when the period is longer than a conversion plus handshake. Otherwise the next window opens right after the capture.
- R10: A stop strobe ends any window, handshake, gap or pending start at once. No capture follows, and `result` and `drdy` are untouched.
- R11: Clearing enable returns the sequencer to idle within two cycles. `result` is kept.
- R12: `drdy_clr` clears `drdy` in the next cycle. A capture in the same cycle wins.
- R13: `status` shows `drdy` in bit 16 and the window-active state in bit 0. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word |
| cdiv_en | input | 1 | Reference divider enable |
| cdiv_val | input | DIV_W | Divider value; tick period is value+1 |
| pud_ticks | input | PUD_W | Power-up delay in conversion ticks |
| period_ticks | input | PER_W | Periodic mode spacing in conversion ticks |
| drdy_clr | input | 1 | Clears the data-ready flag |
| sns_done | input | 1 | Front end sample strobe |
| sns_data | input | DATA_W | Signed sample, 1/64 degree per LSB |
| conv_tick | output | 1 | Conversion clock enable pulse |
| sns_conv | output | 1 | Conversion window active |
| sns_req | output | 1 | Sample requested from the front end |
| result | output | DATA_W | Last captured sample |
| drdy | output | 1 | Data-ready flag |
| status | output | 32 | Status word |

## Verification
The bench measures window lengths and start-to-start spacing in conversion ticks, not cycles. A design that counted off by one, or let the period run from the wrong event, shows a gap one tick off. It stops a continuous run mid-window and fires a done strobe outside a handshake. A design that lets either one through changes `result` or raises `drdy`. It also checks the overrun case of periodic mode, mode 3 and the power-up hold with a start queued on enable. A careless design would repeat the conversion, stall, or convert before the delay ends. Random single conversions vary the resolution, divider and signed data.

// File: rtl/tmeas_pkg.sv
`timescale 1ns/1ps
package tmeas_pkg;
  typedef enum logic [1:0] {
    MODE_ONE  = 2'd0,
    MODE_CONT = 2'd1,
    MODE_PER  = 2'd2,
    MODE_RSV  = 2'd3
  } meas_mode_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WARM,
    ST_READY,
    ST_CONV,
    ST_SAMPLE,
    ST_GAP
  } seq_state_e;

  localparam int CW_EN     = 31;
  localparam int CW_GO     = 30;
  localparam int CW_HALT   = 29;
  localparam int CW_MODE   = 24;
  localparam int CW_RES    = 18;
  localparam int SW_DRDY   = 16;
  localparam int SW_BUSY   = 0;
endpackage

// File: rtl/tmeas_clkdiv.sv
`timescale 1ns/1ps
module tmeas_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div_en,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q >= div_val);
  assign tick = run && (!div_en || wrap);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || !div_en || wrap) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmeas_tickcnt.sv
`timescale 1ns/1ps
module tmeas_tickcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         upd;

  assign upd = clr || (inc && (cnt_q != {W{1'b1}}));

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmeas_fsm.sv
`timescale 1ns/1ps
module tmeas_fsm
  import tmeas_pkg::*;
#(
  parameter int PUD_W  = 8,
  parameter int CONV_W = 15,
  parameter int PER_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  meas_mode_e        mode,
  input  logic              go,
  input  logic              halt,
  input  logic              tick,
  input  logic [PUD_W-1:0]  warm_cnt,
  input  logic [PUD_W-1:0]  pud,
  input  logic [CONV_W-1:0] conv_cnt,
  input  logic [CONV_W-1:0] conv_len,
  input  logic [PER_W-1:0]  per_cnt,
  input  logic [PER_W-1:0]  period,
  input  logic              sns_done,
  output seq_state_e        state,
  output logic              warm_clr,
  output logic              warm_inc,
  output logic              conv_clr,
  output logic              conv_inc,
  output logic              per_clr,
  output logic              per_inc,
  output logic              capture
);
  seq_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       per_due, conv_last, start_conv;

  assign per_due   = tick && (({1'b0, per_cnt} + 1'b1) >= {1'b0, period});
  assign conv_last = tick && (conv_cnt == conv_len - 1'b1);

  always_comb begin
    state_d    = state_q;
    pend_d     = pend_q;
    warm_clr   = 1'b0;
    warm_inc   = 1'b0;
    conv_inc   = 1'b0;
    per_inc    = 1'b0;
    capture    = 1'b0;
    start_conv = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (en) begin
          state_d  = ST_WARM;
          warm_clr = 1'b1;
        end
      end
      ST_WARM: begin
        if (warm_cnt == pud) state_d = ST_READY;
        else                 warm_inc = tick;
      end
      ST_READY: begin
        if (pend_q) begin
          start_conv = 1'b1;
          pend_d     = 1'b0;
        end
      end
      ST_CONV: begin
        per_inc = tick;
        if (halt) state_d = ST_READY;
        else begin
          conv_inc = tick;
          if (conv_last) state_d = ST_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        per_inc = tick;
        if (halt) state_d = ST_READY;
        else if (sns_done) begin
          capture = 1'b1;
          unique case (mode)
            MODE_CONT: start_conv = 1'b1;
            MODE_PER: begin
              if (per_due) start_conv = 1'b1;
              else         state_d    = ST_GAP;
            end
            default: state_d = ST_READY;
          endcase
        end
      end
      ST_GAP: begin
        per_inc = tick;
        if (halt)         state_d    = ST_READY;
        else if (per_due) start_conv = 1'b1;
      end
      default: state_d = ST_OFF;
    endcase

    if (start_conv) state_d = ST_CONV;
    conv_clr = start_conv;
    per_clr  = start_conv;

    if (halt)     pend_d = 1'b0;
    else if (go)  pend_d = 1'b1;
    else if (!en) pend_d = 1'b0;

    if (!en) begin
      state_d  = ST_OFF;
      capture  = 1'b0;
      conv_clr = 1'b0;
      per_clr  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/tmeas_seq.sv
`timescale 1ns/1ps
module tmeas_seq
  import tmeas_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int PUD_W     = 8,
  parameter int PER_W     = 24,
  parameter int RES_W     = 2,
  parameter int DATA_W    = 16,
  parameter int CONV_BASE = 325,
  parameter int CONV_UNIT = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [31:0]       ctrl_wdata,
  input  logic              cdiv_en,
  input  logic [DIV_W-1:0]  cdiv_val,
  input  logic [PUD_W-1:0]  pud_ticks,
  input  logic [PER_W-1:0]  period_ticks,
  input  logic              drdy_clr,
  input  logic              sns_done,
  input  logic [DATA_W-1:0] sns_data,
  output logic              conv_tick,
  output logic              sns_conv,
  output logic              sns_req,
  output logic [DATA_W-1:0] result,
  output logic              drdy,
  output logic [31:0]       status
);
  localparam int RES_MAX  = (1 << RES_W) - 1;
  localparam int CONV_MAX = CONV_BASE + CONV_UNIT * (1 << RES_MAX);
  localparam int CONV_W   = $clog2(CONV_MAX + 1);

  logic              en_q;
  meas_mode_e        mode_q;
  logic [RES_W-1:0]  res_q;
  logic              go, halt;
  logic [DATA_W-1:0] result_q;
  logic              drdy_q;
  logic [CONV_W-1:0] conv_len;
  logic              tick;
  seq_state_e        state;
  logic              warm_clr, warm_inc, conv_clr, conv_inc, per_clr, per_inc, capture;
  logic [PUD_W-1:0]  warm_cnt;
  logic [CONV_W-1:0] conv_cnt;
  logic [PER_W-1:0]  per_cnt;
  logic              unused_wdata;

  assign unused_wdata = ^{ctrl_wdata[28:CW_MODE+2], ctrl_wdata[CW_MODE-1:CW_RES+RES_W],
                          ctrl_wdata[CW_RES-1:0]};

  assign go   = ctrl_wr && ctrl_wdata[CW_GO] && ctrl_wdata[CW_EN];
  assign halt = ctrl_wr && ctrl_wdata[CW_HALT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= MODE_ONE;
      res_q  <= '0;
    end else if (ctrl_wr) begin
      en_q   <= ctrl_wdata[CW_EN];
      mode_q <= meas_mode_e'(ctrl_wdata[CW_MODE+1:CW_MODE]);
      res_q  <= ctrl_wdata[CW_RES+RES_W-1:CW_RES];
    end
  end

  assign conv_len = CONV_W'(CONV_BASE) + (CONV_W'(CONV_UNIT) << res_q);

  tmeas_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(en_q), .div_en(cdiv_en),
    .div_val(cdiv_val), .tick(tick)
  );

  tmeas_tickcnt #(.W(PUD_W)) u_warm (
    .clk(clk), .rst_n(rst_n), .clr(warm_clr), .inc(warm_inc), .cnt(warm_cnt)
  );

  tmeas_tickcnt #(.W(CONV_W)) u_conv (
    .clk(clk), .rst_n(rst_n), .clr(conv_clr), .inc(conv_inc), .cnt(conv_cnt)
  );

  tmeas_tickcnt #(.W(PER_W)) u_per (
    .clk(clk), .rst_n(rst_n), .clr(per_clr), .inc(per_inc), .cnt(per_cnt)
  );

  tmeas_fsm #(.PUD_W(PUD_W), .CONV_W(CONV_W), .PER_W(PER_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q), .go(go), .halt(halt),
    .tick(tick), .warm_cnt(warm_cnt), .pud(pud_ticks), .conv_cnt(conv_cnt),
    .conv_len(conv_len), .per_cnt(per_cnt), .period(period_ticks),
    .sns_done(sns_done), .state(state), .warm_clr(warm_clr), .warm_inc(warm_inc),
    .conv_clr(conv_clr), .conv_inc(conv_inc), .per_clr(per_clr), .per_inc(per_inc),
    .capture(capture)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result_q <= '0;
    else if (capture) result_q <= sns_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   drdy_q <= 1'b0;
    else if (capture || drdy_clr) drdy_q <= capture;
  end

  assign conv_tick = tick;
  assign sns_conv  = (state == ST_CONV);
  assign sns_req   = (state == ST_SAMPLE);
  assign result    = result_q;
  assign drdy      = drdy_q;

  always_comb begin
    status          = '0;
    status[SW_DRDY] = drdy_q;
    status[SW_BUSY] = sns_conv;
  end
endmodule

// File: rtl/tmeas_seq_chk.sv
`timescale 1ns/1ps
module tmeas_seq_chk #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_wr,
  input logic              cw_en,
  input logic              cw_halt,
  input logic              cdiv_en,
  input logic [DIV_W-1:0]  cdiv_val,
  input logic              drdy_clr,
  input logic              sns_done,
  input logic              conv_tick,
  input logic              sns_conv,
  input logic              sns_req,
  input logic [DATA_W-1:0] result,
  input logic              drdy
);
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_tick && cdiv_en && cdiv_val != '0) |=> (!conv_tick || !cdiv_en || cdiv_val == '0));

  p_rdy_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy) |-> $past(sns_req && sns_done));

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $past(sns_req && sns_done));

  p_halt_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && cw_halt && (sns_conv || sns_req)) |=> (!sns_conv && !sns_req));

  p_off_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !cw_en) |-> ##2 (!sns_conv && !sns_req));

  p_clr_rdy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy_clr && !(sns_req && sns_done)) |=> !drdy);
endmodule

bind tmeas_seq tmeas_seq_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .cw_en(ctrl_wdata[31]),
  .cw_halt(ctrl_wdata[29]), .cdiv_en(cdiv_en), .cdiv_val(cdiv_val),
  .drdy_clr(drdy_clr), .sns_done(sns_done), .conv_tick(conv_tick),
  .sns_conv(sns_conv), .sns_req(sns_req), .result(result), .drdy(drdy)
);

// File: tb/tmeas_seq_bench.sv
`timescale 1ns/1ps
module tmeas_seq_bench;
  localparam int BASE = 5;
  localparam int UNIT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_wr;
  logic [31:0] ctrl_wdata;
  logic        cdiv_en;
  logic [7:0]  cdiv_val;
  logic [7:0]  pud_ticks;
  logic [23:0] period_ticks;
  logic        drdy_clr;
  logic        sns_done;
  logic [15:0] sns_data;
  logic        conv_tick, sns_conv, sns_req, drdy;
  logic [15:0] result;
  logic [31:0] status;

  always #10 clk = ~clk;

  tmeas_seq #(.CONV_BASE(BASE), .CONV_UNIT(UNIT)) u_tmeas_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .cdiv_en(cdiv_en), .cdiv_val(cdiv_val), .pud_ticks(pud_ticks),
    .period_ticks(period_ticks), .drdy_clr(drdy_clr), .sns_done(sns_done),
    .sns_data(sns_data), .conv_tick(conv_tick), .sns_conv(sns_conv),
    .sns_req(sns_req), .result(result), .drdy(drdy), .status(status)
  );

  int n_chk = 0, n_bad = 0;
  bit auto_ack = 1'b1, force_done = 1'b0, busy_prev = 1'b0;
  logic [15:0] resp_data = 16'h0000, force_data = 16'h0000;
  int tick_total = 0, rise_at = 0, last_gap = 0, rises = 0;
  int cur_busy = 0, last_len = 0, handshakes = 0;

  function automatic int conv_len(input int res);
    return BASE + (UNIT << res);
  endfunction

  // monitor and front-end model, all at the falling edge
  always @(negedge clk) begin
    if (sns_conv && !busy_prev) begin
      last_gap = tick_total - rise_at;
      rise_at  = tick_total;
      rises++;
      cur_busy = 0;
    end
    if (sns_conv && conv_tick) cur_busy++;
    if (!sns_conv && busy_prev) last_len = cur_busy;
    if (conv_tick) tick_total++;
    busy_prev = sns_conv;
    if (force_done) begin
      sns_done = 1'b1; sns_data = force_data;
    end else if (auto_ack && sns_req) begin
      sns_done = 1'b1; sns_data = resp_data; handshakes++;
    end else begin
      sns_done = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) step();
  endtask

  task automatic wr_ctrl(input bit en, input bit go, input bit halt,
                         input logic [1:0] mode, input logic [1:0] res);
    ctrl_wdata = {en, go, halt, 3'b000, mode, 4'b0000, res, 18'd0};
    ctrl_wr    = 1'b1;
    step();
    ctrl_wr    = 1'b0;
  endtask

  task automatic wait_rises(input int n, input int limit, output bit ok);
    int target = rises + n;
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (rises >= target) begin ok = 1'b1; break; end
      step();
    end
  endtask

  task automatic wait_drdy(input int limit, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (drdy) begin ok = 1'b1; break; end
      step();
    end
  endtask

  task automatic clear_rdy();
    drdy_clr = 1'b1; step(); drdy_clr = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    bit ok;
    int t0, r0, hs;
    logic [15:0] keep;
    void'($urandom(32'd5150));
    rst_n = 1'b0; ctrl_wr = 1'b0; ctrl_wdata = '0; cdiv_en = 1'b0; cdiv_val = '0;
    pud_ticks = 8'd20; period_ticks = 24'd40; drdy_clr = 1'b0;
    sns_done = 1'b0; sns_data = '0;
    wait_cyc(5);
    rst_n = 1'b1;
    step();

    // reset state
    chk(result == 16'h0, "R13 reset result", result, 0);
    chk(status == 32'h0 && !drdy, "R13 reset status", status, 0);
    chk(!conv_tick && !sns_conv, "R2 no tick while off", conv_tick, 0);

    // power-up hold with start queued on enable
    resp_data = 16'hFF3A;
    t0 = tick_total;
    wr_ctrl(1, 1, 0, 2'd0, 2'd0);
    wait_rises(1, 500, ok);
    chk(ok && (rise_at - t0) >= 20 && (rise_at - t0) <= 24, "R3 power-up ticks", rise_at - t0, 23);
    wait_drdy(300, ok);
    chk(ok, "R5 drdy raised", ok, 1);
    chk(last_len == conv_len(0), "R4 window res0", last_len, conv_len(0));
    chk(result == 16'hFF3A, "R5 signed capture", result, 16'hFF3A);
    chk(status == 32'h0001_0000, "R13 status drdy bit16", status, 32'h0001_0000);
    r0 = rises;
    wait_cyc(100);
    chk(rises == r0, "R7 single stops", rises, r0);

    clear_rdy();
    chk(!drdy, "R12 clear", drdy, 0);

    // stray done
    force_data = 16'h1234;
    force_done = 1'b1; step(); force_done = 1'b0;
    wait_cyc(2);
    chk(result == 16'hFF3A, "R6 stray done result", result, 16'hFF3A);
    chk(!drdy, "R6 stray done drdy", drdy, 0);

    // mode 3 acts as single, res field 1
    resp_data = 16'h0040;
    wr_ctrl(1, 1, 0, 2'd3, 2'd1);
    wait_drdy(300, ok);
    r0 = rises;
    wait_cyc(150);
    chk(ok && rises == r0, "R1 mode3 single", rises, r0);
    chk(last_len == conv_len(1), "R4 window res1", last_len, conv_len(1));
    chk(result == 16'h0040, "R1 capture mode3", result, 16'h0040);
    clear_rdy();

    // continuous
    resp_data = 16'h0A00;
    wr_ctrl(1, 1, 0, 2'd1, 2'd1);
    wait_rises(4, 400, ok);
    chk(ok && last_gap == conv_len(1) + 1, "R8 continuous spacing", last_gap, conv_len(1) + 1);

    // stop mid-window
    while (!sns_conv) step();
    wait_cyc(3);
    hs = handshakes; keep = result;
    wr_ctrl(1, 0, 1, 2'd1, 2'd1);
    chk(!sns_conv && !sns_req, "R10 stop ends window", sns_conv, 0);
    r0 = rises;
    wait_cyc(100);
    chk(rises == r0 && handshakes == hs, "R10 nothing after stop", rises, r0);
    chk(result == keep, "R10 result kept", result, keep);

    // periodic
    resp_data = 16'h0123;
    wr_ctrl(1, 1, 0, 2'd2, 2'd0);
    wait_rises(4, 600, ok);
    chk(ok && last_gap == 40, "R9 periodic spacing", last_gap, 40);
    period_ticks = 24'd5;
    wait_rises(3, 300, ok);
    chk(ok && last_gap == conv_len(0) + 1, "R9 overrun spacing", last_gap, conv_len(0) + 1);
    wr_ctrl(1, 0, 1, 2'd2, 2'd0);

    // disable returns to idle
    resp_data = 16'h7FC0;
    wr_ctrl(1, 1, 0, 2'd1, 2'd0);
    wait_rises(3, 300, ok);
    wr_ctrl(0, 0, 0, 2'd1, 2'd0);
    step();
    chk(!sns_conv && !sns_req, "R11 idle after disable", sns_conv, 0);
    r0 = rises;
    wait_cyc(80);
    chk(rises == r0 && !conv_tick, "R11 stays idle", rises, r0);
    chk(result == 16'h7FC0, "R11 result kept", result, 16'h7FC0);
    wr_ctrl(0, 1, 0, 2'd0, 2'd0);
    wait_cyc(80);
    chk(rises == r0, "R7 start ignored while disabled", rises, r0);

    // divider
    cdiv_en = 1'b1; cdiv_val = 8'd3;
    wr_ctrl(1, 0, 0, 2'd0, 2'd0);
    wait_cyc(10);
    t0 = tick_total; wait_cyc(40);
    chk(tick_total - t0 == 10, "R2 divided ticks", tick_total - t0, 10);
    cdiv_en = 1'b0;
    step();
    t0 = tick_total; wait_cyc(40);
    chk(tick_total - t0 == 40, "R2 undivided ticks", tick_total - t0, 40);
    wr_ctrl(0, 0, 0, 2'd0, 2'd0);
    step();
    t0 = tick_total; wait_cyc(20);
    chk(tick_total - t0 == 0, "R2 no ticks when off", tick_total - t0, 0);

    // random single conversions
    pud_ticks = 8'd3;
    for (int i = 0; i < 14; i++) begin
      int res;
      logic [15:0] data;
      res  = int'($urandom_range(3, 0));
      data = 16'($urandom);
      wr_ctrl(0, 0, 0, 2'd0, 2'd0);
      cdiv_en  = 1'($urandom_range(1, 0));
      cdiv_val = 8'($urandom_range(3, 0));
      resp_data = data;
      clear_rdy();
      wr_ctrl(1, 1, 0, 2'd0, 2'(res));
      wait_drdy(1000, ok);
      chk(ok, "R5 random drdy", ok, 1);
      chk(last_len == conv_len(res), "R4 random window", last_len, conv_len(res));
      chk(result == data, "R5 random data", result, data);
    end

    summary();
    $finish;
  end
endmodule